// File: doc/BRIEF.md
# Split-Mode Event Counter Bank with Staged Writes

This block holds a small bank of physical event counters behind a 64-bit register bus. Each physical counter runs either as one 32-bit counter or as two independent 16-bit counters, so four physical counters give eight logical counters. Software addresses the logical counters, and the block maps each one onto the right half of a physical counter. A per-counter size bit in the control register picks the mode.

Writes from software do not reach the live counters directly. Each write lands in a staging latch for its physical counter. The latch is copied into the live counter only when the control register is written with its run bit set. This happens both when the bank is first started and when the control register is written again while the bank is already running. Counters count their event inputs only while the run bit is set. When a counter wraps, it sets a sticky pending bit. The interrupt output is raised from the pending bits that the mask allows. Reading the status register returns the pending bits and clears them in the same access.

Top module: `split_pmon_bank`

## Requirements
- R1: After synchronous reset, all live counters, latches, control registers, pending bits and the mask are zero. `irq` and `bus_rdata` are also zero.
- R2: Writing a logical counter (address 0..7) changes only its staging latch. A read of that logical counter still shows the live value until a commit.
- R3: Writing the control register (address 0x10) with bit 31 set copies every staged latch into its live counter, whether or not the bank was already running. Physical counters with no staged write keep their live value.
- R4: While control bit 31 is set, each physical counter in 32-bit mode adds one on every cycle that `evt[p]` is high. While bit 31 is clear, no counter changes.
- R5: With control bit p set (16-bit mode), logical p is the upper half of physical p and counts `evt[p]`. Logical p+4 is the lower half and counts `evt[p+4]`. Neither half carries into the other.
- R6: In 16-bit mode, a write to logical p replaces only the upper half of the latch. A write to logical p+4 replaces only the lower half. The other half of the latch keeps its staged content.
- R7: When physical p is in 32-bit mode, writes to logical p+4 are ignored and reads of it return zero.
- R8: Every register carries its 32-bit value in bus bits 63:32. Write bits 31:0 are ignored, and read bits 31:0 are zero. `bus_rdata` is loaded on the edge that samples `bus_rd` and then holds until the next read.
- R9: The eight per-logical-counter control words (addresses 0x08..0x0F) store and return 32 bits each.
- R10: A 16-bit half wrapping from 0xFFFF to 0 sets pending bit p (upper half) or bit p+4 (lower half). A 32-bit counter wrapping from 0xFFFFFFFF sets pending bit p.
- R11: Reading status (address 0x11) returns the pending bits in payload bits 7:0 and clears them. A wrap in the same cycle as the read stays pending.
- R12: Writing status loads the 8-bit interrupt mask. `irq` is high one cycle after any pending bit is high and its mask bit is set. A zero mask keeps `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 64 | Write word, payload in bits 63:32 |
| bus_rdata | output | 64 | Registered read word, payload in bits 63:32 |
| evt | input | 8 | Event inputs, one per logical counter |
| irq | output | 1 | Masked overflow interrupt |

## Verification
The bench writes counters while the bank is stopped and while it is running, then reads them before and after a control rewrite. A design that let writes reach the live counter early, or that committed only on the first start, would show the new value too soon or never. In 16-bit mode, it drives a lower half through 0xFFFF while watching the upper half. A design that carried across the halves or lost the unwritten half of the latch would corrupt the neighbouring logical counter. It checks that status clears on read and that a zero mask holds `irq` low. It also checks that the upper logical bank is dead in 32-bit mode, which catches a design that merged those writes into the low half.

// File: rtl/pmb_pkg.sv
package pmb_pkg;
  localparam int DW     = 32;  // payload and counter width
  localparam int BW     = 64;  // bus word width
  localparam int RUN_BIT = 31; // control: run / commit bit

  typedef enum logic [1:0] {
    RG_CNT  = 2'd0,
    RG_CCTL = 2'd1,
    RG_MISC = 2'd2,
    RG_NONE = 2'd3
  } region_e;
endpackage

// File: rtl/pmb_phys_ctr.sv
module pmb_phys_ctr #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          split,
  input  logic          commit,
  input  logic          lat_wr,
  input  logic          lat_we_hi,
  input  logic          lat_we_lo,
  input  logic [CW-1:0] lat_din,
  input  logic          ev_hi,
  input  logic          ev_lo,
  output logic [CW-1:0] live,
  output logic [CW-1:0] lat,
  output logic          staged,
  output logic          ovf_hi,
  output logic          ovf_lo
);
  localparam int HW = CW / 2;

  logic [CW-1:0] live_q, lat_q;
  logic          staged_q;
  logic          load;

  assign load = commit && staged_q;

  always_comb begin
    ovf_hi = 1'b0;
    ovf_lo = 1'b0;
    if (run && !load) begin
      if (split) begin
        ovf_hi = ev_hi && (live_q[CW-1:HW] == '1);
        ovf_lo = ev_lo && (live_q[HW-1:0] == '1);
      end else begin
        ovf_hi = ev_hi && (live_q == '1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q   <= '0;
      lat_q    <= '0;
      staged_q <= 1'b0;
    end else begin
      if (lat_wr) begin
        if (lat_we_hi) lat_q[CW-1:HW] <= lat_din[CW-1:HW];
        if (lat_we_lo) lat_q[HW-1:0]  <= lat_din[HW-1:0];
      end
      if (lat_wr)      staged_q <= 1'b1;
      else if (commit) staged_q <= 1'b0;

      if (load) begin
        live_q <= lat_q;
      end else if (run) begin
        if (split) begin
          live_q[CW-1:HW] <= live_q[CW-1:HW] + {{(HW-1){1'b0}}, ev_hi};
          live_q[HW-1:0]  <= live_q[HW-1:0]  + {{(HW-1){1'b0}}, ev_lo};
        end else begin
          live_q <= live_q + {{(CW-1){1'b0}}, ev_hi};
        end
      end
    end
  end

  assign live   = live_q;
  assign lat    = lat_q;
  assign staged = staged_q;
endmodule

// File: rtl/pmb_irq_stat.sv
module pmb_irq_stat #(
  parameter int NL = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NL-1:0] ovf,
  input  logic          rd_clr,
  input  logic          mask_we,
  input  logic [NL-1:0] mask_din,
  output logic [NL-1:0] pend,
  output logic [NL-1:0] mask,
  output logic          irq
);
  logic [NL-1:0] pend_q, mask_q;
  logic          irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~{NL{rd_clr}}) | ovf;
      if (mask_we) mask_q <= mask_din;
      irq_q <= |(pend_q & mask_q);
    end
  end

  assign pend = pend_q;
  assign mask = mask_q;
  assign irq  = irq_q;
endmodule

// File: rtl/split_pmon_bank.sv
module split_pmon_bank
  import pmb_pkg::*;
#(
  parameter  int NP = 4,
  localparam int NL = 2 * NP,
  localparam int PW = $clog2(NP),
  localparam int LW = PW + 1,
  localparam int AW = LW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [BW-1:0] bus_wdata,
  output logic [BW-1:0] bus_rdata,
  input  logic [NL-1:0] evt,
  output logic          irq
);
  localparam int HW = DW / 2;

  region_e        region;
  logic [LW-1:0]  lidx;
  logic [PW-1:0]  pidx;
  logic           upper_bank;
  logic [DW-1:0]  wval;

  assign region     = region_e'(bus_addr[AW-1:LW]);
  assign lidx       = bus_addr[LW-1:0];
  assign pidx       = lidx[PW-1:0];
  assign upper_bank = lidx[PW];
  assign wval       = bus_wdata[BW-1:BW-DW];

  logic [DW-1:0] ctrl_q;
  logic [DW-1:0] cctl_q [NL];
  logic          run;
  logic [NP-1:0] split;
  logic          ctrl_we, commit, stat_we, stat_rd;

  assign run     = ctrl_q[RUN_BIT];
  assign split   = ctrl_q[NP-1:0];
  assign ctrl_we = bus_wr && (region == RG_MISC) && !bus_addr[0];
  assign commit  = ctrl_we && wval[RUN_BIT];
  assign stat_we = bus_wr && (region == RG_MISC) && bus_addr[0];
  assign stat_rd = bus_rd && (region == RG_MISC) && bus_addr[0];

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= wval;
  end

  generate
    for (genvar l = 0; l < NL; l++) begin : g_cctl
      always_ff @(posedge clk) begin
        if (rst) cctl_q[l] <= '0;
        else if (bus_wr && (region == RG_CCTL) && (lidx == LW'(l))) cctl_q[l] <= wval;
      end
    end
  endgenerate

  logic [NP-1:0][DW-1:0] live_a, lat_a;
  logic [NP-1:0]         staged_a, ovf_hi_a, ovf_lo_a;
  logic [NL-1:0]         ovf;

  generate
    for (genvar p = 0; p < NP; p++) begin : g_phys
      logic hit, lw, we_hi, we_lo;
      logic [DW-1:0] din;
      assign hit   = bus_wr && (region == RG_CNT) && (pidx == PW'(p));
      assign lw    = hit && (split[p] || !upper_bank);
      assign we_hi = !split[p] || !upper_bank;
      assign we_lo = !split[p] || upper_bank;
      assign din   = split[p] ? {wval[HW-1:0], wval[HW-1:0]} : wval;

      pmb_phys_ctr #(.CW(DW)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .split     (split[p]),
        .commit    (commit),
        .lat_wr    (lw),
        .lat_we_hi (we_hi),
        .lat_we_lo (we_lo),
        .lat_din   (din),
        .ev_hi     (evt[p]),
        .ev_lo     (evt[p+NP]),
        .live      (live_a[p]),
        .lat       (lat_a[p]),
        .staged    (staged_a[p]),
        .ovf_hi    (ovf_hi_a[p]),
        .ovf_lo    (ovf_lo_a[p])
      );
      assign ovf[p]    = ovf_hi_a[p];
      assign ovf[p+NP] = ovf_lo_a[p];
    end
  endgenerate

  logic [NL-1:0] pend, mask;

  pmb_irq_stat #(.NL(NL)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .ovf      (ovf),
    .rd_clr   (stat_rd),
    .mask_we  (stat_we),
    .mask_din (wval[NL-1:0]),
    .pend     (pend),
    .mask     (mask),
    .irq      (irq)
  );

  logic [DW-1:0] cnt_rd, rd_val, sel_live;

  assign sel_live = live_a[pidx];

  always_comb begin
    if (split[pidx])
      cnt_rd = upper_bank ? {{HW{1'b0}}, sel_live[HW-1:0]}
                          : {{HW{1'b0}}, sel_live[DW-1:HW]};
    else
      cnt_rd = upper_bank ? '0 : sel_live;
  end

  always_comb begin
    unique case (region)
      RG_CNT:  rd_val = cnt_rd;
      RG_CCTL: rd_val = cctl_q[lidx];
      RG_MISC: rd_val = bus_addr[0] ? {{(DW-NL){1'b0}}, pend} : ctrl_q;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= {rd_val, {(BW-DW){1'b0}}};
  end
endmodule

// File: rtl/pmb_chk.sv
module pmb_chk #(
  parameter int NP = 4,
  parameter int CW = 32,
  parameter int NL = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  bus_rd,
  input logic [63:0]           bus_rdata,
  input logic                  irq,
  input logic                  run,
  input logic                  commit,
  input logic                  stat_rd,
  input logic [NP-1:0][CW-1:0] live_a,
  input logic [NP-1:0][CW-1:0] lat_a,
  input logic [NP-1:0]         staged_a,
  input logic [NL-1:0]         pend,
  input logic [NL-1:0]         mask,
  input logic [NL-1:0]         ovf
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst) $fell(rst) |-> !irq); // R1
  AST_LIVE_FROZEN: assert property (@(posedge clk) disable iff (rst) (!commit && !run) |=> $stable(live_a)); // R2
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst) (|(pend & mask)) |=> irq); // R12
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst) !(|(pend & mask)) |=> !irq); // R12
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst) (stat_rd && ovf == '0) |=> pend == '0); // R11
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst) !bus_rd |=> $stable(bus_rdata)); // R8

  generate
    for (genvar p = 0; p < NP; p++) begin : g_cm
      AST_COMMIT_LOAD: assert property (@(posedge clk) disable iff (rst) (commit && staged_a[p]) |=> live_a[p] == $past(lat_a[p])); // R3
    end
  endgenerate
endmodule

bind split_pmon_bank pmb_chk #(.NP(NP), .CW(pmb_pkg::DW), .NL(NL)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .run       (run),
  .commit    (commit),
  .stat_rd   (stat_rd),
  .live_a    (live_a),
  .lat_a     (lat_a),
  .staged_a  (staged_a),
  .pend      (pend),
  .mask      (mask),
  .ovf       (ovf)
);

// File: tb/split_pmon_bank_test.sv
`timescale 1ns/1ps
module split_pmon_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic [7:0]  evt = '0;
  logic        irq;
  int total = 0, bad = 0;

  localparam logic [4:0] A_CTRL = 5'h10, A_STAT = 5'h11;
  localparam logic [31:0] RUN = 32'h8000_0000;

  always #10 clk = ~clk;

  split_pmon_bank uut (.clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt(evt), .irq(irq));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] v, input logic [31:0] lo = 32'h0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = {v, lo};
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [63:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic pulse(input logic [7:0] m, input int n);
    @(negedge clk);
    evt = m;
    repeat (n) @(negedge clk);
    evt = '0;
  endtask

  function automatic logic [63:0] pl(input logic [31:0] v);
    return {v, 32'h0};
  endfunction

  task automatic t_reset();
    logic [63:0] v;
    rd(A_CTRL, v); chk("R1 ctrl", v, 64'h0);
    rd(5'h00, v);  chk("R1 ctr0", v, 64'h0);
    chk("R1 irq", {63'h0, irq}, 64'h0);
  endtask

  task automatic t_stage_commit();
    logic [63:0] v;
    wr(5'h00, 32'd100);
    rd(5'h00, v); chk("R2 staged only", v, pl(0));
    wr(A_CTRL, RUN);
    rd(5'h00, v); chk("R3 first commit", v, pl(100));
    pulse(8'h01, 5);
    rd(5'h00, v); chk("R4 count", v, pl(105));
    wr(5'h00, 32'd7);
    rd(5'h00, v); chk("R2 staged while running", v, pl(105));
    wr(A_CTRL, RUN);
    rd(5'h00, v); chk("R3 recommit", v, pl(7));
    rd(5'h01, v); chk("R3 unstaged kept", v, pl(0));
  endtask

  task automatic t_stopped();
    logic [63:0] v;
    wr(A_CTRL, 32'h0);
    pulse(8'h01, 4);
    rd(5'h00, v); chk("R4 stopped", v, pl(7));
  endtask

  task automatic t_bus();
    logic [63:0] v;
    wr(5'h01, 32'h55, 32'hFFFF_FFFF);
    wr(A_CTRL, RUN);
    rd(5'h01, v); chk("R8 payload word", v, pl(32'h55));
    rd(A_CTRL, v); chk("R8 ctrl readback", v, pl(RUN));
  endtask

  task automatic t_cctl();
    logic [63:0] v;
    wr(5'h0D, 32'hDEAD_BEEF);
    rd(5'h0D, v); chk("R9 cctl store", v, pl(32'hDEAD_BEEF));
    rd(5'h0C, v); chk("R9 cctl neighbour", v, pl(0));
  endtask

  task automatic t_split();
    logic [63:0] v;
    wr(A_CTRL, 32'h4);
    wr(5'h02, 32'h1234);
    wr(5'h06, 32'hFFFE);
    rd(5'h02, v); chk("R2 split staged", v, pl(0));
    wr(A_CTRL, RUN | 32'h4);
    rd(5'h02, v); chk("R6 upper half", v, pl(32'h1234));
    rd(5'h06, v); chk("R6 lower half", v, pl(32'hFFFE));
    pulse(8'h40, 2);
    rd(5'h06, v); chk("R5 lower wrap", v, pl(0));
    rd(5'h02, v); chk("R5 no carry", v, pl(32'h1234));
    pulse(8'h04, 3);
    rd(5'h02, v); chk("R5 upper count", v, pl(32'h1237));
  endtask

  task automatic t_status();
    logic [63:0] v;
    rd(A_STAT, v); chk("R10 R11 pending", v, pl(32'h40));
    rd(A_STAT, v); chk("R11 cleared", v, pl(0));
  endtask

  task automatic t_irq();
    logic [63:0] v;
    wr(A_STAT, 32'h40);
    wr(5'h06, 32'hFFFF);
    wr(A_CTRL, RUN | 32'h4);
    pulse(8'h40, 1);
    @(negedge clk);
    chk("R12 irq raised", {63'h0, irq}, 64'h1);
    rd(A_STAT, v); chk("R11 read pending", v, pl(32'h40));
    @(negedge clk);
    chk("R12 irq dropped", {63'h0, irq}, 64'h0);
    wr(A_STAT, 32'h0);
    wr(5'h06, 32'hFFFF);
    wr(A_CTRL, RUN | 32'h4);
    pulse(8'h40, 1);
    repeat (2) @(negedge clk);
    chk("R12 masked", {63'h0, irq}, 64'h0);
    rd(A_STAT, v); chk("R10 masked pending", v, pl(32'h40));
  endtask

  task automatic t_wrap32();
    logic [63:0] v;
    wr(5'h03, 32'hFFFF_FFFF);
    wr(A_CTRL, RUN | 32'h4);
    pulse(8'h08, 1);
    rd(5'h03, v); chk("R10 wrap32 value", v, pl(0));
    rd(A_STAT, v); chk("R10 wrap32 pending", v, pl(32'h08));
  endtask

  task automatic t_dead_bank();
    logic [63:0] v;
    wr(5'h07, 32'h99);
    wr(A_CTRL, RUN | 32'h4);
    rd(5'h03, v); chk("R7 write ignored", v, pl(0));
    rd(5'h07, v); chk("R7 reads zero", v, pl(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_stage_commit();
    t_stopped();
    t_bus();
    t_cctl();
    t_split();
    t_status();
    t_irq();
    t_wrap32();
    t_dead_bank();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule